// File: doc/BRIEF.md
# Supervisory Reset Pulse Generator

This block generates the processor reset for a power supervisor. Its inputs are digitised flags from external comparators: one says the supply is under the reset threshold, the other says the supply is under the backup battery voltage. It also takes a timeout strobe from a watchdog block and a tick from a slow timebase. While either supply flag is set, reset is held asserted. After both flags clear, reset stays asserted for a hold period counted in timebase ticks. A watchdog timeout that arrives while reset is released fires one reset pulse of the same length.

Beside the reset pair, the block has two outputs that react at once to the threshold flag. The low-line status follows the threshold flag with no stretching. The chip-enable output passes the chip-enable input through while the supply is healthy and forces it to its inactive level while the supply is low. A select input picks a short or a long hold length. It is sampled each time the hold count is loaded.

Top module: `supv_reset_gen`

## Requirements
- R1: `rst_out_n` is 0 in the same cycle that `below_thr` or `below_batt` is 1, and it stays 0 for as long as either one is 1.
- R2: Once both supply flags are 0, `rst_out_n` stays 0 until the block has counted HOLD_SHORT ticks (when `hold_long` was 0 at load) or HOLD_LONG ticks (when `hold_long` was 1 at load). It goes to 1 at the clock edge that samples the last of those ticks.
- R3: A `wdt_expire` pulse while reset is released and the supply is good sets `rst_out_n` to 0 at the next edge. `rst_out_n` then stays 0 for a full hold period, timed as in R2.
- R4: `rst_out` is always the logical inverse of `rst_out_n`.
- R5: `low_line_n` equals the inverse of `below_thr` in the same cycle, with no stretching.
- R6: `ce_out_n` equals `ce_in_n` while `below_thr` is 0, and is forced to 1 while `below_thr` is 1.
- R7: If a supply flag rises again during the hold period, the count restarts. The full hold is counted again after the flag clears.
- R8: While `rst_n` is low, `rst_out_n` is 0 and the hold count is loaded. The first release comes only after a full hold period.
- R9: A `wdt_expire` pulse while reset is already asserted neither extends nor restarts the current hold period.
- R10: `below_batt` alone asserts reset but leaves `low_line_n` at 1 and leaves `ce_out_n` following `ce_in_n`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous power-on reset, active low |
| tick | input | 1 | Timebase strobe, one cycle wide per tick |
| below_thr | input | 1 | Supply is under the reset threshold |
| below_batt | input | 1 | Supply is under the backup battery voltage |
| wdt_expire | input | 1 | Watchdog timeout strobe |
| hold_long | input | 1 | 1 selects the long hold length, 0 the short one |
| ce_in_n | input | 1 | Chip-enable input, active low |
| rst_out_n | output | 1 | Processor reset, active low |
| rst_out | output | 1 | Processor reset, active high |
| low_line_n | output | 1 | Low-line status, active low |
| ce_out_n | output | 1 | Gated chip-enable, active low |

## Verification
The assertions assume that all inputs are synchronous to `clk`, and that `tick` and `wdt_expire` are single-cycle strobes sampled at the clock edge. They also assume the hold select is only meaningful when the count is loaded. The stimulus changes every input on the falling edge and drives the tick at regular periods of one and three cycles. It also places watchdog strobes and supply dips both inside and outside the hold window, so the restart and ignore paths are exercised under these assumptions.

// File: rtl/supv_reset_gen.sv
module supv_reset_gen #(
  parameter int HOLD_SHORT = 4,
  parameter int HOLD_LONG  = 10
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tick,
  input  logic below_thr,
  input  logic below_batt,
  input  logic wdt_expire,
  input  logic hold_long,
  input  logic ce_in_n,
  output logic rst_out_n,
  output logic rst_out,
  output logic low_line_n,
  output logic ce_out_n
);
  localparam int CW = $clog2(HOLD_LONG + 1);
  localparam logic [CW-1:0] LEN_S = CW'(HOLD_SHORT);
  localparam logic [CW-1:0] LEN_L = CW'(HOLD_LONG);

  logic          active;
  logic [CW-1:0] cnt;
  logic          supply_bad;
  logic [CW-1:0] load_len;

  assign supply_bad = below_thr | below_batt;
  assign load_len   = hold_long ? LEN_L : LEN_S;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active <= 1'b1;
      cnt    <= load_len;
    end else if (supply_bad) begin
      active <= 1'b1;
      cnt    <= load_len;
    end else if (active) begin
      if (tick) begin
        if (cnt <= CW'(1)) begin
          active <= 1'b0;
          cnt    <= '0;
        end else begin
          cnt <= cnt - CW'(1);
        end
      end
    end else if (wdt_expire) begin
      active <= 1'b1;
      cnt    <= load_len;
    end
  end

  assign rst_out_n  = ~(active | supply_bad);
  assign rst_out    = ~rst_out_n;
  assign low_line_n = ~below_thr;
  assign ce_out_n   = below_thr ? 1'b1 : ce_in_n;

  AST_BAD_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    supply_bad |=> active) else $error("bad supply did not hold reset"); // R1
  AST_RELEASE_ON_TICK: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(active) |-> ($past(tick) && !$past(supply_bad))) else $error("release without tick"); // R2
  AST_WDT_FIRES: assert property (@(posedge clk) disable iff (!rst_n)
    (!active && !supply_bad && wdt_expire) |=> (active && cnt != '0)) else $error("watchdog pulse missing"); // R3
  AST_WDT_NO_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
    (active && !supply_bad && !tick && wdt_expire) |=> $stable(cnt)) else $error("watchdog disturbed hold"); // R9
  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= LEN_L) else $error("hold count out of range"); // R2
  AST_RESTART_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    (supply_bad && !hold_long) |=> (cnt == LEN_S)) else $error("dip did not reload count"); // R7
endmodule

// File: tb/sim_supv_reset_gen.sv
module sim_supv_reset_gen;
  localparam int CLK_P = 10;
  localparam int HS = 4;
  localparam int HL = 10;

  logic clk = 0, rst_n = 0, tick = 0, below_thr = 0, below_batt = 0;
  logic wdt_expire = 0, hold_long = 0, ce_in_n = 1;
  logic rst_out_n, rst_out, low_line_n, ce_out_n;

  supv_reset_gen #(.HOLD_SHORT(HS), .HOLD_LONG(HL)) u0 (
    .clk(clk), .rst_n(rst_n), .tick(tick), .below_thr(below_thr),
    .below_batt(below_batt), .wdt_expire(wdt_expire), .hold_long(hold_long),
    .ce_in_n(ce_in_n), .rst_out_n(rst_out_n), .rst_out(rst_out),
    .low_line_n(low_line_n), .ce_out_n(ce_out_n));

  always #(CLK_P/2) clk = ~clk;

  typedef struct {
    logic rn, r, ll, ce;
    string tag;
  } exp_t;

  exp_t q[$];
  int checks = 0, fails = 0;
  bit m_act = 1;
  int m_cnt = HS;

  task automatic chk(input logic act, input logic ex, input string tag, input string what);
    checks++;
    if (act !== ex) begin
      fails++;
      $display("FAIL %s %s actual=%b expected=%b", tag, what, act, ex);
    end
  endtask

  task automatic step(input bit tk, input bit bt, input bit bb, input bit wd,
                      input bit sel, input bit ce, input string tag);
    exp_t e;
    int len;
    @(negedge clk);
    tick = tk; below_thr = bt; below_batt = bb; wdt_expire = wd;
    hold_long = sel; ce_in_n = ce;
    len = sel ? HL : HS;
    if (bt || bb) begin m_act = 1; m_cnt = len; end
    else if (m_act) begin
      if (tk) begin
        if (m_cnt <= 1) begin m_act = 0; m_cnt = 0; end
        else m_cnt--;
      end
    end else if (wd) begin m_act = 1; m_cnt = len; end
    e.rn = !(m_act || bt || bb);
    e.r  = !e.rn;
    e.ll = !bt;
    e.ce = bt ? 1'b1 : ce;
    e.tag = tag;
    q.push_back(e);
  endtask

  initial begin
    forever begin
      @(posedge clk);
      #(CLK_P/4);
      if (q.size() > 0) begin
        exp_t e;
        e = q.pop_front();
        chk(rst_out_n, e.rn, e.tag, "rst_out_n");
        chk(rst_out, e.r, "R4", "rst_out");
        chk(low_line_n, e.ll, e.tag, "low_line_n");
        chk(ce_out_n, e.ce, e.tag, "ce_out_n");
      end
    end
  end

  initial begin
    #(CLK_P * 200000);
    fails++;
    $display("FAIL watchdog expired actual=hung expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    #(CLK_P * 2 + 2);
    chk(rst_out_n, 1'b0, "R8", "rst_out_n during reset");
    chk(rst_out, 1'b1, "R4", "rst_out during reset");
    @(negedge clk);
    rst_n = 1;
    // R8 R2: power-on full short hold, tick every third cycle
    for (int i = 0; i < 18; i++) step(i % 3 == 0, 0, 0, 0, 0, 1, "R8");
    // R6: chip-enable passes through while healthy
    for (int i = 0; i < 4; i++) step(0, 0, 0, 0, 0, i[0], "R6");
    // R3: watchdog pulse, then hold with tick every cycle
    step(0, 0, 0, 1, 0, 1, "R3");
    for (int i = 0; i < 7; i++) step(1, 0, 0, 0, 0, 1, "R3");
    // R9: watchdog during hold is ignored
    step(0, 0, 0, 1, 0, 1, "R9");
    for (int i = 0; i < 12; i++) step(i % 3 == 0, 0, 0, (i == 2 || i == 5), 0, 1, "R9");
    // R1 R5 R6: below threshold with chip enable active
    for (int i = 0; i < 3; i++) step(i == 1, 1, 0, 0, 1, 0, "R1");
    for (int i = 0; i < 3; i++) step(0, 1, 0, 0, 1, 0, "R5");
    // R2 R7: long hold with a dip part way through
    for (int i = 0; i < 8; i++) step(1, 0, 0, 0, 1, 0, "R2");
    step(0, 1, 0, 0, 1, 0, "R7");
    for (int i = 0; i < 14; i++) step(1, 0, 0, 0, 1, 0, "R7");
    // R10: battery flag alone
    for (int i = 0; i < 3; i++) step(1, 0, 1, 0, 0, i[0], "R10");
    for (int i = 0; i < 8; i++) step(1, 0, 0, 0, 0, 0, "R10");
    step(0, 0, 0, 0, 0, 1, "R2");
    step(0, 0, 0, 0, 0, 1, "R2");
    @(negedge clk);
    @(negedge clk);
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule